// File: doc/BRIEF.md
# Link Error Interrupt Register Block

This block gathers error and warning events from a packet link controller and turns them into one interrupt request line. Most events come in as single-cycle pulses from the link logic or from the ECC and CRC logic elsewhere. Three events are generated inside the block, from packet header fields and retry outcomes:

- A sequence-continuity checker compares each received 3-bit sequence number with the previous one.
- A length checker compares the length field of each received packet with its duplicate-length field.
- A counter tracks consecutive failed retry attempts.

Each event sets a sticky status bit. Software reads the status bit and clears it by writing a one. A per-source enable register and a global gate decide whether the latched status raises `irq`.

Software reaches the block through a plain 32-bit register port. A write takes effect at the next clock edge. Reads are combinational from the address. No data flows through the block, so the port has no valid/ready handshake. All inputs are assumed to be synchronous to `clk`.

Top module: `link_irq_regs`

## Requirements
- R1: After reset the status register (offset 0x20), the enable register (0x24) and the global gate register (0x28) all read 0, and `irq` is 0.
- R2: Only bits 0-6, 8, 9 and 11-15 exist in the status and enable registers (mask 0x0000FB7F). The global gate register has only bit 0. All other bits read 0 and ignore writes.
- R3: Writing 1 to a status bit clears it at the next edge. Writing 0 to a status bit leaves it unchanged.
- R4: If a source event and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: `irq` is 1 exactly when the global gate bit is 1 and at least one status bit is 1 with its enable bit also 1.
- R6: For each packet header (`pkt_hdr_valid`), status bit 2 is set if `pkt_seq` is not the previous header's sequence number plus one, modulo 8.
  - The first header after reset only sets the reference and raises no error.
  - Each header then becomes the new reference.
- R7: For each packet header, status bit 1 is set if any of these holds:
  - `pkt_len` differs from `pkt_dup_len`.
  - `pkt_len` is 0.
  - `pkt_len` is above the maximum of 9.
- R8: Status bit 4 is set on the third consecutive `retry_fail` pulse, and on every further failure, until a `retry_ok` pulse resets the count. If `retry_ok` and `retry_fail` arrive in the same cycle, `retry_ok` wins and no event is raised.
- R9: Each cycle in which the active-low `dev_fatal_n` input is 0 sets status bit 13.
- R10: Pulse inputs set these status bits:

  | Input | Status bit |
  |---|---|
  | `crc_fail` | 0 |
  | `remote_retry` | 3 |
  | `err_rsp` | 5 |
  | `err_rsp_ovf` | 6 |
  | `retry_buf_full` | 8 |
  | `tokens_out` | 9 |
  | `retry_mem_ecc_fix` | 11 |
  | `retry_mem_ecc_bad` | 12 |
  | `rsp_mem_ecc_fix` | 14 |
  | `rsp_mem_ecc_bad` | 15 |

- R11: Reads from any address other than 0x20, 0x24 and 0x28 return 0. Writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| crc_fail | input | 1 | CRC failure pulse |
| pkt_hdr_valid | input | 1 | Packet header fields valid this cycle |
| pkt_seq | input | 3 | Header sequence number |
| pkt_len | input | 5 | Header length field |
| pkt_dup_len | input | 5 | Header duplicate-length field |
| remote_retry | input | 1 | Remote retry request pulse |
| retry_fail | input | 1 | Retry attempt failed |
| retry_ok | input | 1 | Retry attempt succeeded |
| err_rsp | input | 1 | Error response received |
| err_rsp_ovf | input | 1 | Error response dropped on overflow |
| retry_buf_full | input | 1 | Retry buffer full |
| tokens_out | input | 1 | Flow-control tokens exhausted |
| dev_fatal_n | input | 1 | Device fatal error, active low |
| retry_mem_ecc_fix | input | 1 | Retry memory correctable ECC hit |
| retry_mem_ecc_bad | input | 1 | Retry memory uncorrectable ECC hit |
| rsp_mem_ecc_fix | input | 1 | Response memory correctable ECC hit |
| rsp_mem_ecc_bad | input | 1 | Response memory uncorrectable ECC hit |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:

- **Sequence wrap.** A header with sequence 0 after 7 must be accepted. A checker that drops the modulo would flag every wrap.
- **First header after reset.** It must not be flagged. A checker without a reference flag would raise a spurious error right out of reset.
- **Retry failures.** Exactly two failures must stay silent and the third must fire. A counter that is cleared by the wrong pulse, or that wraps instead of saturating, would fire early, late, or stop firing after a long run of failures.
- **Same-cycle set and clear.** A status bit hit by an event and a clearing write in the same cycle must stay set. A design where the clear wins would lose the event.
- **Reserved and unmapped locations.** Writing ones there must leave them reading zero.
- **Global gate.** Closing the gate must drop `irq` while status and enables stay set.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
  localparam int OFF_STAT = 'h20;
  localparam int OFF_EN   = 'h24;
  localparam int OFF_GLB  = 'h28;

  // status bit positions
  localparam int B_CRC  = 0;
  localparam int B_LEN  = 1;
  localparam int B_SEQ  = 2;
  localparam int B_RMT  = 3;
  localparam int B_FAT  = 4;
  localparam int B_ERSP = 5;
  localparam int B_EOVF = 6;
  localparam int B_RBF  = 8;
  localparam int B_TOK  = 9;
  localparam int B_RBCE = 11;
  localparam int B_RBUE = 12;
  localparam int B_DEV  = 13;
  localparam int B_RQCE = 14;
  localparam int B_RQUE = 15;

  localparam logic [31:0] SRC_MASK = 32'h0000_FB7F;
endpackage

// File: rtl/link_seq_check.sv
module link_seq_check #(
  parameter int SEQ_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_v,
  input  logic [SEQ_W-1:0] seq,
  output logic             seq_err
);
  logic             have_ref_q;
  logic [SEQ_W-1:0] prev_q;
  logic [SEQ_W-1:0] expect_seq;

  assign expect_seq = prev_q + SEQ_W'(1);
  assign seq_err    = hdr_v && have_ref_q && (seq != expect_seq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_ref_q <= 1'b0;
      prev_q     <= '0;
    end else if (hdr_v) begin
      have_ref_q <= 1'b1;
      prev_q     <= seq;
    end
  end
endmodule

// File: rtl/link_len_check.sv
module link_len_check #(
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 9
) (
  input  logic             hdr_v,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] dup_len,
  output logic             len_err
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic mismatch, out_of_range;

  assign mismatch     = (len != dup_len);
  assign out_of_range = (len == '0) || (len > LEN_MAX);
  assign len_err      = hdr_v && (mismatch || out_of_range);
endmodule

// File: rtl/link_retry_count.sv
module link_retry_count #(
  parameter int FAIL_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic ok,
  output logic fatal_ev
);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FAIL_LIMIT);
  localparam logic [CNT_W-1:0] ARM   = CNT_W'(FAIL_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign fatal_ev = fail && !ok && (cnt_q >= ARM);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (ok)                     cnt_q <= '0;
    else if (fail && cnt_q != LIMIT) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/link_irq_regs.sv
module link_irq_regs
  import link_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SEQ_W      = 3,
  parameter int LEN_W      = 5,
  parameter int MAX_LEN    = 9,
  parameter int FAIL_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              crc_fail,
  input  logic              pkt_hdr_valid,
  input  logic [SEQ_W-1:0]  pkt_seq,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [LEN_W-1:0]  pkt_dup_len,
  input  logic              remote_retry,
  input  logic              retry_fail,
  input  logic              retry_ok,
  input  logic              err_rsp,
  input  logic              err_rsp_ovf,
  input  logic              retry_buf_full,
  input  logic              tokens_out,
  input  logic              dev_fatal_n,
  input  logic              retry_mem_ecc_fix,
  input  logic              retry_mem_ecc_bad,
  input  logic              rsp_mem_ecc_fix,
  input  logic              rsp_mem_ecc_bad,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_GLB  = ADDR_W'(OFF_GLB);

  logic        seq_err, len_err, fatal_ev;
  logic [31:0] ev_vec;
  logic [31:0] stat_q, en_q;
  logic        glb_q;
  logic        hit_stat, hit_en, hit_glb;
  logic [31:0] clr_vec;

  link_seq_check #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hdr_v(pkt_hdr_valid), .seq(pkt_seq),
    .seq_err(seq_err)
  );

  link_len_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_len (
    .hdr_v(pkt_hdr_valid), .len(pkt_len), .dup_len(pkt_dup_len),
    .len_err(len_err)
  );

  link_retry_count #(.FAIL_LIMIT(FAIL_LIMIT)) u_rty (
    .clk(clk), .rst_n(rst_n), .fail(retry_fail), .ok(retry_ok),
    .fatal_ev(fatal_ev)
  );

  always_comb begin
    ev_vec         = '0;
    ev_vec[B_CRC]  = crc_fail;
    ev_vec[B_LEN]  = len_err;
    ev_vec[B_SEQ]  = seq_err;
    ev_vec[B_RMT]  = remote_retry;
    ev_vec[B_FAT]  = fatal_ev;
    ev_vec[B_ERSP] = err_rsp;
    ev_vec[B_EOVF] = err_rsp_ovf;
    ev_vec[B_RBF]  = retry_buf_full;
    ev_vec[B_TOK]  = tokens_out;
    ev_vec[B_RBCE] = retry_mem_ecc_fix;
    ev_vec[B_RBUE] = retry_mem_ecc_bad;
    ev_vec[B_DEV]  = !dev_fatal_n;
    ev_vec[B_RQCE] = rsp_mem_ecc_fix;
    ev_vec[B_RQUE] = rsp_mem_ecc_bad;
  end

  assign hit_stat = bus_wr && (bus_addr == A_STAT);
  assign hit_en   = bus_wr && (bus_addr == A_EN);
  assign hit_glb  = bus_wr && (bus_addr == A_GLB);
  assign clr_vec  = hit_stat ? bus_wdata : '0;

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      glb_q  <= 1'b0;
    end else begin
      stat_q <= ((stat_q & ~clr_vec) | ev_vec) & SRC_MASK;
      if (hit_en)  en_q  <= bus_wdata & SRC_MASK;
      if (hit_glb) glb_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)     bus_rdata = stat_q;
    else if (bus_addr == A_EN)  bus_rdata = en_q;
    else if (bus_addr == A_GLB) bus_rdata = {31'b0, glb_q};
  end

  assign irq = glb_q && ((stat_q & en_q) != '0);
endmodule

// File: rtl/link_irq_chk.sv
module link_irq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              dev_fatal_n,
  input logic [31:0]       ev_vec,
  input logic [31:0]       stat_q,
  input logic [31:0]       en_q,
  input logic              glb_q,
  input logic              irq
);
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[31:16] == '0) && !bus_rdata[7] && !bus_rdata[10]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h20)) |=>
      ((stat_q & $past(bus_wdata) & ~$past(ev_vec)) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != '0) |=> ((stat_q & $past(ev_vec)) == $past(ev_vec)));

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_q |-> !irq);

  p_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_q & en_q) != '0));

  p_dev_fatal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_fatal_n |=> stat_q[13]);
endmodule

bind link_irq_regs link_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_fatal_n(dev_fatal_n),
  .ev_vec(ev_vec), .stat_q(stat_q), .en_q(en_q), .glb_q(glb_q), .irq(irq)
);

// File: tb/test_link_irq_regs.sv
module test_link_irq_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h0000_FB7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h20;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        crc_fail = 0, pkt_hdr_valid = 0, remote_retry = 0;
  logic [2:0]  pkt_seq = '0;
  logic [4:0]  pkt_len = '0, pkt_dup_len = '0;
  logic        retry_fail = 0, retry_ok = 0, err_rsp = 0, err_rsp_ovf = 0;
  logic        retry_buf_full = 0, tokens_out = 0, dev_fatal_n = 1;
  logic        retry_mem_ecc_fix = 0, retry_mem_ecc_bad = 0;
  logic        rsp_mem_ecc_fix = 0, rsp_mem_ecc_bad = 0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_stat = '0, m_en = '0;
  logic        m_glb = 0, m_ref = 0;
  logic [2:0]  m_prev = '0;
  int          m_cnt = 0;

  link_irq_regs i_link_irq_regs (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_events();
    logic [31:0] e = '0;
    e[0] = crc_fail; e[3] = remote_retry; e[5] = err_rsp; e[6] = err_rsp_ovf;
    e[8] = retry_buf_full; e[9] = tokens_out; e[11] = retry_mem_ecc_fix;
    e[12] = retry_mem_ecc_bad; e[13] = !dev_fatal_n;
    e[14] = rsp_mem_ecc_fix; e[15] = rsp_mem_ecc_bad;
    if (pkt_hdr_valid) begin
      e[1] = (pkt_len != pkt_dup_len) || (pkt_len == 0) || (pkt_len > 9);
      e[2] = m_ref && (int'(pkt_seq) != (int'(m_prev) + 1) % 8);
    end
    e[4] = retry_fail && !retry_ok && (m_cnt + 1 >= 3);
    return e;
  endfunction

  // apply current inputs at the next edge, update model, then check
  task automatic step();
    logic [31:0] ev, clr;
    ev = model_events();
    clr = '0;
    if (bus_wr) begin
      if (bus_addr == 8'h20) clr = bus_wdata;
      else if (bus_addr == 8'h24) m_en = bus_wdata & MASK;
      else if (bus_addr == 8'h28) m_glb = bus_wdata[0];
    end
    m_stat = ((m_stat & ~clr) | ev) & MASK;
    if (pkt_hdr_valid) begin m_ref = 1; m_prev = pkt_seq; end
    if (retry_ok) m_cnt = 0;
    else if (retry_fail && m_cnt < 3) m_cnt++;
    @(posedge clk);
    #1;
    {crc_fail, pkt_hdr_valid, remote_retry, retry_fail, retry_ok} = '0;
    {err_rsp, err_rsp_ovf, retry_buf_full, tokens_out} = '0;
    {retry_mem_ecc_fix, retry_mem_ecc_bad, rsp_mem_ecc_fix, rsp_mem_ecc_bad} = '0;
    dev_fatal_n = 1; bus_wr = 0; bus_addr = 8'h20;
    #1;
    chk("R10 status", bus_rdata, m_stat);
    chk("R5 irq", {31'b0, irq}, {31'b0, m_glb && ((m_stat & m_en) != 0)});
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
    bus_addr = 8'h20;
  endtask

  task automatic hdr(logic [2:0] s, logic [4:0] l, logic [4:0] d);
    pkt_hdr_valid = 1; pkt_seq = s; pkt_len = l; pkt_dup_len = d;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset values
    rd_chk("R1 status", 8'h20, 0);
    rd_chk("R1 enable", 8'h24, 0);
    rd_chk("R1 global", 8'h28, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R6 first header is reference only, then wrap 7->0 accepted
    hdr(3'd5, 5'd4, 5'd4); chk("R6 first hdr", {31'b0, m_stat[2]}, 0);
    rd_chk("R6 first hdr port", 8'h20, 32'h0);
    hdr(3'd6, 5'd4, 5'd4); hdr(3'd7, 5'd4, 5'd4); hdr(3'd0, 5'd4, 5'd4);
    rd_chk("R6 wrap ok", 8'h20, 32'h0);
    hdr(3'd2, 5'd4, 5'd4);
    rd_chk("R6 gap flagged", 8'h20, 32'h4);
    wr(8'h20, 32'hFFFF_FFFF);
    hdr(3'd3, 5'd4, 5'd4);
    rd_chk("R6 resync", 8'h20, 32'h0);

    // R7 length checks
    hdr(3'd4, 5'd9, 5'd9);  rd_chk("R7 max ok", 8'h20, 32'h0);
    hdr(3'd5, 5'd0, 5'd0);  rd_chk("R7 zero", 8'h20, 32'h2);
    wr(8'h20, 32'h2);
    hdr(3'd6, 5'd10, 5'd10); rd_chk("R7 too big", 8'h20, 32'h2);
    wr(8'h20, 32'h2);
    hdr(3'd7, 5'd3, 5'd4);  rd_chk("R7 mismatch", 8'h20, 32'h2);
    wr(8'h20, 32'h2);

    // R8 retry exhaustion
    retry_fail = 1; step(); retry_fail = 1; step();
    rd_chk("R8 two fails", 8'h20, 32'h0);
    retry_fail = 1; step();
    rd_chk("R8 third fail", 8'h20, 32'h10);
    wr(8'h20, 32'h10);
    retry_fail = 1; step();
    rd_chk("R8 saturated", 8'h20, 32'h10);
    wr(8'h20, 32'h10);
    retry_ok = 1; step();
    retry_fail = 1; step(); retry_fail = 1; step();
    rd_chk("R8 reset by ok", 8'h20, 32'h0);
    retry_fail = 1; retry_ok = 1; step();
    rd_chk("R8 ok wins", 8'h20, 32'h0);

    // R9 device fatal pin
    dev_fatal_n = 0; step();
    rd_chk("R9 dev fatal", 8'h20, 32'h2000);
    wr(8'h20, 32'hFFFF);

    // R10 pulse map
    crc_fail = 1; remote_retry = 1; err_rsp = 1; err_rsp_ovf = 1;
    retry_buf_full = 1; tokens_out = 1; retry_mem_ecc_fix = 1;
    retry_mem_ecc_bad = 1; rsp_mem_ecc_fix = 1; rsp_mem_ecc_bad = 1;
    step();
    rd_chk("R10 map", 8'h20, 32'h0000_DB69);

    // R3 write-one-to-clear, write zero no effect
    wr(8'h20, 32'h0);
    rd_chk("R3 zero write", 8'h20, 32'h0000_DB69);
    wr(8'h20, 32'h1);
    rd_chk("R3 clear bit0", 8'h20, 32'h0000_DB68);

    // R4 set beats clear
    crc_fail = 1; bus_wr = 1; bus_addr = 8'h20; bus_wdata = 32'h1; step();
    rd_chk("R4 set wins", 8'h20, 32'h0000_DB69);

    // R2 reserved bits
    wr(8'h24, 32'hFFFF_FFFF);
    rd_chk("R2 enable mask", 8'h24, 32'h0000_FB7F);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R2 global mask", 8'h28, 32'h1);

    // R5 gate
    chk("R5 irq on", {31'b0, irq}, 1);
    wr(8'h28, 32'h0);
    chk("R5 gate off", {31'b0, irq}, 0);
    wr(8'h28, 32'h1);
    wr(8'h24, 32'h0000_0002);
    chk("R5 no enabled src", {31'b0, irq}, 0);

    // R11 unmapped
    wr(8'h2C, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped read", 8'h2C, 32'h0);
    rd_chk("R11 enable kept", 8'h24, 32'h2);
    rd_chk("R11 status kept", 8'h20, 32'h0000_DB69);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] s;
      s = ($urandom % 4 != 0) ? m_prev + 3'd1 : 3'($urandom);
      pkt_hdr_valid = ($urandom % 2) == 1;
      pkt_seq = s;
      pkt_len = 5'($urandom % 12);
      pkt_dup_len = ($urandom % 4 != 0) ? pkt_len : 5'($urandom % 12);
      crc_fail = ($urandom % 16) == 0;
      remote_retry = ($urandom % 16) == 0;
      err_rsp = ($urandom % 16) == 0;
      err_rsp_ovf = ($urandom % 16) == 0;
      retry_buf_full = ($urandom % 16) == 0;
      tokens_out = ($urandom % 16) == 0;
      retry_mem_ecc_fix = ($urandom % 16) == 0;
      retry_mem_ecc_bad = ($urandom % 16) == 0;
      rsp_mem_ecc_fix = ($urandom % 16) == 0;
      rsp_mem_ecc_bad = ($urandom % 16) == 0;
      dev_fatal_n = ($urandom % 32) != 0;
      retry_fail = ($urandom % 3) == 0;
      retry_ok = ($urandom % 8) == 0;
      bus_wr = ($urandom % 3) == 0;
      bus_addr = 8'h20 + 8'(4 * ($urandom % 4));
      bus_wdata = $urandom;
      step();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule